// File: doc/BRIEF.md
# Big-endian masked data memory port

This block is the data-side access unit that sits between a CPU core and a byte-addressed on-chip RAM of 2^P bytes. In any cycle the core may issue one access: a byte, a 16-bit word or a 32-bit long, as a read or a write. A read request also carries a flag that selects sign or zero extension of a narrow result. Read data comes back on the clock after the request. Writes produce no response.

The block never faults on an address. The address is reduced modulo the memory size, so accesses wrap around. Word and long addresses are then forced down to their natural alignment. Multi-byte values are held most-significant byte first. A write touches only the bytes covered by its size, so narrow stores can be mixed freely with wide loads.

The storage depth is a parameter. The default is a small 4 KiB so that the unit elaborates quickly. A full-size build sets `MEM_LOG2` to 19 for 512 KiB.

Top module: `bemem_port`

## Requirements
- R1: The effective address keeps only the low `MEM_LOG2` bits of `req_addr`, so any two addresses that differ only above that bit reach the same bytes.
- R2: For a word access (size code 01), bit 0 of the effective address is forced to 0.
- R3: For a long access, bits 1:0 of the effective address are forced to 0.
- R4: A long at effective address A holds data bits 31:24 at byte A, 23:16 at A+1, 15:8 at A+2 and 7:0 at A+3, for both writes and reads.
- R5: A word at effective address A holds data bits 15:8 at byte A and bits 7:0 at A+1. A word write takes its value from `req_wdata[15:0]`.
- R6: A byte read (size code 00) returns the byte in bits 7:0. Bits 31:8 copy bit 7 when `req_signed` is 1 and are 0 when it is 0. A byte write stores `req_wdata[7:0]`.
- R7: A word read returns the word in bits 15:0. Bits 31:16 copy bit 15 when `req_signed` is 1 and are 0 when it is 0.
- R8: A write changes only the bytes selected by its size at its effective address. Every other byte keeps its value.
- R9: A read accepted at a clock edge sets `rsp_valid` high for exactly the next cycle, with its data on `rsp_rdata`. A write or an idle cycle leaves `rsp_valid` low in the next cycle.
- R10: A read issued in the cycle directly after a write to the same bytes returns the newly written value.
- R11: Size code 10 selects a long, and the otherwise unused code 11 also acts as a long. Long reads ignore `req_signed`.
- R12: During and after reset, until the first read, `rsp_valid` is 0. Whenever `rsp_valid` is 0, `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 word, 10 or 11 long |
| req_signed | input | 1 | Sign-extend a narrow read result |
| req_addr | input | ADDR_W | Byte address, wrapped and aligned inside |
| req_wdata | input | 32 | Write value, right-justified for narrow writes |
| rsp_valid | output | 1 | Read data present |
| rsp_rdata | output | 32 | Read result, extended per size and flag |

## Verification
A wrong effective address or a wrong lane mask does not show when it happens. It shows only when a later read lands on the damaged or missed bytes. For that reason the reference model mirrors every byte and the bench reads back neighbouring bytes after narrow writes. Faults in the response path are visible at once: a stale size or offset in the pipeline register, or a wrong extension, corrupts the data of that very read one cycle after issue. The checker catches a mistimed `rsp_valid` or a badly extended upper half on the same clock.

// File: rtl/bemem_pkg.sv
package bemem_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;
    localparam logic [1:0] SZ_LONG = 2'b10;

    // Control carried alongside a read into the response cycle
    typedef struct packed {
        logic       rd;
        logic [1:0] off;
        logic [1:0] size;
        logic       sext;
    } rd_ctl_t;

endpackage

// File: rtl/bemem_align.sv
module bemem_align
    import bemem_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MEM_LOG2 = 12,
    localparam int IDX_W   = MEM_LOG2 - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [IDX_W-1:0]  idx,
    output logic [1:0]        off,
    output logic [LANES-1:0]  lane_en
);
    logic [MEM_LOG2-1:0] eff;
    logic                unused_hi;

    // Bits above the memory size wrap away (R1)
    assign unused_hi = ^addr[ADDR_W-1:MEM_LOG2];

    always_comb begin
        eff = addr[MEM_LOG2-1:0];
        unique case (size)
            SZ_BYTE: lane_en = 4'b1000 >> eff[1:0];
            SZ_WORD: begin
                eff[0]  = 1'b0;                       // R2
                lane_en = 4'b1100 >> eff[1:0];
            end
            default: begin
                eff[1:0] = 2'b00;                     // R3
                lane_en  = 4'b1111;
            end
        endcase
        idx = eff[MEM_LOG2-1:2];
        off = eff[1:0];
    end

endmodule

// File: rtl/bemem_lane_ram.sv
module bemem_lane_ram
    import bemem_pkg::*;
#(
    parameter int IDX_W = 10,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] wimg,
    output logic [DATA_W-1:0] rword
);
    // Lane j holds image bits 8j+7:8j; lane 3 is the lowest byte address
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && lane_en[j]) begin
                store[idx] <= wimg[LANE_W*j +: LANE_W];
            end
            if (rd_en) begin
                rd_q <= store[idx];
            end
        end

        assign rword[LANE_W*j +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/bemem_extract.sv
module bemem_extract
    import bemem_pkg::*;
(
    input  logic [DATA_W-1:0] rword,
    input  rd_ctl_t           ctl,
    output logic [DATA_W-1:0] rdata
);
    logic [7:0]  sel_b;
    logic [15:0] sel_w;

    always_comb begin
        unique case (ctl.off)
            2'd0:    sel_b = rword[31:24];
            2'd1:    sel_b = rword[23:16];
            2'd2:    sel_b = rword[15:8];
            default: sel_b = rword[7:0];
        endcase
        sel_w = ctl.off[1] ? rword[15:0] : rword[31:16];

        if (!ctl.rd) begin
            rdata = '0;
        end else begin
            unique case (ctl.size)
                SZ_BYTE: rdata = {{24{ctl.sext & sel_b[7]}}, sel_b};
                SZ_WORD: rdata = {{16{ctl.sext & sel_w[15]}}, sel_w};
                default: rdata = rword;
            endcase
        end
    end

endmodule

// File: rtl/bemem_port.sv
module bemem_port
    import bemem_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MEM_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);
    localparam int IDX_W = MEM_LOG2 - 2;

    logic [IDX_W-1:0]  idx;
    logic [1:0]        off;
    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] wimg;
    logic [DATA_W-1:0] rword;
    logic              wr_en;
    logic              rd_en;
    rd_ctl_t           ctl_d, ctl_q;

    bemem_align #(
        .ADDR_W  (ADDR_W),
        .MEM_LOG2(MEM_LOG2)
    ) u_align (
        .addr   (req_addr),
        .size   (req_size),
        .idx    (idx),
        .off    (off),
        .lane_en(lane_en)
    );

    always_comb begin
        wr_en = req_valid & req_write;
        rd_en = req_valid & ~req_write;
        // Narrow values are replicated; the lane mask picks the right copy
        unique case (req_size)
            SZ_BYTE: wimg = {4{req_wdata[7:0]}};
            SZ_WORD: wimg = {2{req_wdata[15:0]}};
            default: wimg = req_wdata;
        endcase
        ctl_d.rd   = rd_en;
        ctl_d.off  = off;
        ctl_d.size = req_size;
        ctl_d.sext = req_signed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bemem_lane_ram #(
        .IDX_W(IDX_W)
    ) u_ram (
        .clk    (clk),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .idx    (idx),
        .lane_en(lane_en),
        .wimg   (wimg),
        .rword  (rword)
    );

    bemem_extract u_ext (
        .rword(rword),
        .ctl  (ctl_q),
        .rdata(rsp_rdata)
    );

    assign rsp_valid = ctl_q.rd;

endmodule

// File: rtl/bemem_port_chk.sv
module bemem_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic        req_signed,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata
);
    a_r9_read_gets_response: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rsp_valid);

    a_r9_write_no_response: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |=> !rsp_valid);

    a_r9_no_spurious_response: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    a_r12_quiet_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_rdata == 32'h0);

    a_r6_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_size) == 2'b00 && !$past(req_signed)
        |-> rsp_rdata[31:8] == 24'h0);

    a_r6_byte_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_size) == 2'b00 && $past(req_signed)
        |-> rsp_rdata[31:8] == {24{rsp_rdata[7]}});

    a_r7_word_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_size) == 2'b01 && !$past(req_signed)
        |-> rsp_rdata[31:16] == 16'h0);

    a_r7_word_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_size) == 2'b01 && $past(req_signed)
        |-> rsp_rdata[31:16] == {16{rsp_rdata[15]}});

endmodule

bind bemem_port bemem_port_chk u_chk (.*);

// File: tb/bemem_port_bench.sv
`timescale 1ns/1ps
module bemem_port_bench;
    localparam int MEM_LOG2 = 12;
    localparam int MEMB     = 1 << MEM_LOG2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_signed = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem_m [MEMB];

    always #4 clk = ~clk;

    bemem_port #(.ADDR_W(32), .MEM_LOG2(MEM_LOG2)) u_bemem_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic int ea_of(logic [31:0] a, logic [1:0] sz);
        int e = int'(a % MEMB);
        if (sz == 2'b00) return e;
        if (sz == 2'b01) return e - (e % 2);
        return e - (e % 4);
    endfunction

    function automatic logic [31:0] ref_read(logic [31:0] a, logic [1:0] sz, bit sg);
        int e = ea_of(a, sz);
        if (sz == 2'b00) return sg ? {{24{mem_m[e][7]}}, mem_m[e]} : {24'h0, mem_m[e]};
        if (sz == 2'b01) return sg ? {{16{mem_m[e][7]}}, mem_m[e], mem_m[e+1]}
                                   : {16'h0, mem_m[e], mem_m[e+1]};
        return {mem_m[e], mem_m[e+1], mem_m[e+2], mem_m[e+3]};
    endfunction

    task automatic ref_write(logic [31:0] a, logic [1:0] sz, logic [31:0] d);
        int e = ea_of(a, sz);
        if (sz == 2'b00) mem_m[e] = d[7:0];
        else if (sz == 2'b01) begin
            mem_m[e] = d[15:8]; mem_m[e+1] = d[7:0];
        end else begin
            mem_m[e] = d[31:24]; mem_m[e+1] = d[23:16];
            mem_m[e+2] = d[15:8]; mem_m[e+3] = d[7:0];
        end
    endtask

    task automatic check(string tag, bit ev, logic [31:0] ed);
        checks++;
        if (rsp_valid !== ev || rsp_rdata !== ed) begin
            errors++;
            $display("FAIL %s: actual valid=%0b data=%08h expected valid=%0b data=%08h",
                     tag, rsp_valid, rsp_rdata, ev, ed);
        end
    endtask

    // Called at a falling edge; checks the response one cycle later
    task automatic access(bit wr, logic [1:0] sz, bit sg, logic [31:0] a,
                          logic [31:0] wd, string tag);
        bit          ev;
        logic [31:0] ed;
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_signed = sg; req_addr = a; req_wdata = wd;
        @(posedge clk);
        if (wr) begin
            ref_write(a, sz, wd); ev = 1'b0; ed = '0;
        end else begin
            ev = 1'b1; ed = ref_read(a, sz, sg);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, ev, ed);
    endtask

    task automatic idle(string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset", 1'b0, 32'h0);
        rst_n = 1'b1;
        idle("R12 after reset");

        for (int i = 0; i < MEMB / 4; i++)
            access(1'b1, 2'b10, 1'b0, 32'(i * 4), 32'(i) * 32'h9E3779B1, "R4 init");

        // R4 long layout, read back by bytes and as a long
        access(1'b1, 2'b10, 1'b0, 32'h100, 32'h11223344, "R4");
        for (int k = 0; k < 4; k++) access(1'b0, 2'b00, 1'b0, 32'h100 + 32'(k), 0, "R4 byte");
        access(1'b0, 2'b10, 1'b0, 32'h100, 0, "R4 long");

        // R5 word layout
        access(1'b1, 2'b01, 1'b0, 32'h202, 32'hFFFFA5B6, "R5");
        access(1'b0, 2'b00, 1'b0, 32'h202, 0, "R5 high byte");
        access(1'b0, 2'b00, 1'b0, 32'h203, 0, "R5 low byte");
        access(1'b0, 2'b10, 1'b0, 32'h200, 0, "R5 long view");

        // R1 wrap of high address bits
        access(1'b1, 2'b00, 1'b0, 32'hFFFF_F105, 32'h0000_00C7, "R1 write");
        access(1'b0, 2'b00, 1'b0, 32'h105, 0, "R1 read");
        access(1'b0, 2'b10, 1'b0, 32'h8000_0104, 0, "R1 long");

        // R2 / R3 alignment
        access(1'b0, 2'b01, 1'b0, 32'h203, 0, "R2 odd word");
        access(1'b1, 2'b01, 1'b0, 32'h301, 32'h0000_1234, "R2 odd write");
        access(1'b0, 2'b10, 1'b0, 32'h300, 0, "R2 long view");
        access(1'b0, 2'b10, 1'b0, 32'h103, 0, "R3 misaligned");
        access(1'b1, 2'b10, 1'b0, 32'h40E, 32'hCAFEF00D, "R3 write");
        access(1'b0, 2'b10, 1'b0, 32'h40C, 0, "R3 read");

        // R6 / R7 extension
        access(1'b1, 2'b10, 1'b0, 32'h500, 32'h80F17F85, "R6 setup");
        access(1'b0, 2'b00, 1'b1, 32'h500, 0, "R6 signed neg");
        access(1'b0, 2'b00, 1'b0, 32'h500, 0, "R6 unsigned");
        access(1'b0, 2'b00, 1'b1, 32'h502, 0, "R6 signed pos");
        access(1'b0, 2'b01, 1'b1, 32'h500, 0, "R7 signed neg");
        access(1'b0, 2'b01, 1'b0, 32'h500, 0, "R7 unsigned");
        access(1'b0, 2'b01, 1'b1, 32'h502, 0, "R7 signed pos");

        // R8 narrow writes keep neighbours
        access(1'b1, 2'b00, 1'b0, 32'h601, 32'hAABBCC5A, "R8 byte");
        access(1'b0, 2'b10, 1'b0, 32'h600, 0, "R8 after byte");
        access(1'b0, 2'b10, 1'b0, 32'h5FC, 0, "R8 prev long");
        access(1'b1, 2'b01, 1'b0, 32'h606, 32'h99998877, "R8 word");
        access(1'b0, 2'b10, 1'b0, 32'h604, 0, "R8 after word");
        access(1'b0, 2'b10, 1'b0, 32'h600, 0, "R8 lower long");

        // R10 back-to-back write then read, R9 idle gaps
        access(1'b1, 2'b10, 1'b0, 32'h700, 32'h0BADBEEF, "R10 write");
        access(1'b0, 2'b10, 1'b0, 32'h700, 0, "R10 read");
        access(1'b1, 2'b00, 1'b0, 32'h703, 32'h00000012, "R10 byte write");
        access(1'b0, 2'b00, 1'b0, 32'h703, 0, "R10 byte read");
        idle("R9 idle");
        idle("R9 idle 2");

        // R11 size code 11 and ignored sign on longs
        access(1'b1, 2'b11, 1'b1, 32'h806, 32'h87654321, "R11 write");
        access(1'b0, 2'b10, 1'b1, 32'h804, 0, "R11 signed long");
        access(1'b0, 2'b11, 1'b0, 32'h805, 0, "R11 code 11 read");

        // Mixed traffic against the model
        for (int n = 0; n < 600; n++) begin
            logic [1:0] sz = 2'($urandom_range(0, 3));
            bit wr = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 7) == 0) idle("R9 random idle");
            access(wr, sz, 1'($urandom_range(0, 1)), $urandom(), $urandom(), "R8 random mix");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule